// File: doc/BRIEF.md
# QPSK Carrier Lock Detector

This block decides whether the carrier recovery loop of a digital QPSK demodulator is locked. It takes the signed in-phase and quadrature samples that the demodulator produces once per symbol, with gain control and symbol timing assumed already correct. For each symbol it forms a metric from the two magnitudes. A comparator finds the larger of |I| and |Q|, and the smaller one is subtracted from it. The datapath has no multiplier and no squared or fourth-power term.

The per-symbol metrics are summed over an observation window of M symbols. When the window closes, the total is compared with a programmable threshold. The lock flag is raised only if the total is strictly greater than the threshold. The window length is a runtime input. It is taken when each window begins, so a window that has already started is not disturbed when the input changes. At the close of each window the block issues a one-cycle done pulse, shows the total of the window just ended, and keeps both the total and the lock decision until the next window closes.

Top module: `qpsk_lock_detect`

## Requirements
- R1: While the synchronous active-high reset is asserted, the block clears its symbol count and accumulator. After reset, lockFlag reads 0 (unlocked), winDone reads 0 and accSum reads 0.
- R2: Each 8-bit two's-complement sample is turned into its magnitude. The code -128 saturates to a magnitude of 127.
- R3: The per-symbol metric is the larger of |I| and |Q| minus the smaller one, so it lies in the range 0 to 127.
- R4: A window is winLenM1+1 strobed symbols, from 1 to 256. winDone is high for exactly one cycle: the cycle after the clock edge that captures the last symbol of the window.
- R5: When winDone is high, accSum holds the sum of the metrics of the window just closed. Accumulation then starts again from zero. accSum keeps its value at all other times.
- R6: lockFlag is set to (window sum > threshold), with threshold treated as unsigned and the comparison strict. It is updated only when winDone is high and holds otherwise.
- R7: A cycle with symValid low changes neither the accumulator nor the symbol count. The sample inputs are ignored on such cycles.
- R8: winLenM1 is taken at the first symbol of each window. A change made to it during a window has no effect until the next window starts.
- R9: A window of 256 full-scale metrics (sum 32512) is accumulated without overflow in the 16-bit accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| symValid | input | 1 | Symbol strobe; samples are taken only when it is high |
| iSample | input | 8 | In-phase sample, two's complement |
| qSample | input | 8 | Quadrature sample, two's complement |
| threshold | input | 16 | Lock threshold, unsigned |
| winLenM1 | input | 8 | Window length minus one |
| lockFlag | output | 1 | Registered lock decision |
| accSum | output | 16 | Metric sum of the last closed window |
| winDone | output | 1 | One-cycle pulse when a window closes |

## Verification
The bench uses one-symbol windows to sweep every I/Q pair. This catches a design that mishandles -128, whether by wrapping it to a negative magnitude or by treating it as 128, and a design that subtracts the wrong way and wraps. Two 128-symbol windows with idle gaps carry garbage on the sample inputs; a design that samples without the strobe would collect extra metric. The threshold is set once to the sum minus one and once to the sum itself, which separates a strict comparison from a non-strict one. A mid-window change of the window length and a full 256-symbol window at full scale expose a design that reloads the length early or that uses an accumulator too narrow for the worst case.

// File: rtl/qpsk_lock_pkg.sv
package qpsk_lock_pkg;

  // Strobes handed from the window control to the datapath each cycle.
  typedef struct packed {
    logic take;   // a symbol is consumed this cycle
    logic first;  // it opens a new window
    logic last;   // it closes the current window
  } lockStrobes_t;

endpackage

// File: rtl/lock_mag.sv
module lock_mag #(
  parameter int SAMPLE_W = 8
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic        [SAMPLE_W-2:0] mag
);
  localparam logic [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  logic [SAMPLE_W-1:0] negated;

  always_comb begin
    negated = -sample;
    if (sample == MOST_NEG)
      mag = '1;                                  // saturate: R2
    else if (sample[SAMPLE_W-1])
      mag = negated[SAMPLE_W-2:0];
    else
      mag = sample[SAMPLE_W-2:0];
  end
endmodule

// File: rtl/lock_control.sv
module lock_control
  import qpsk_lock_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             symValid,
  input  logic [CNT_W-1:0] winLenM1,
  output lockStrobes_t     strobes,
  output logic             winDone
);
  logic [CNT_W-1:0] symCnt;
  logic [CNT_W-1:0] limitReg;
  logic [CNT_W-1:0] effLimit;
  logic             atStart;

  always_comb begin
    atStart       = (symCnt == '0);
    effLimit      = atStart ? winLenM1 : limitReg;   // taken at window start: R8
    strobes.take  = symValid;
    strobes.first = symValid && atStart;
    strobes.last  = symValid && (symCnt == effLimit);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      symCnt   <= '0;
      limitReg <= '0;
      winDone  <= 1'b0;
    end else begin
      winDone <= strobes.last;
      if (symValid) begin
        if (atStart) limitReg <= winLenM1;
        if (strobes.last) symCnt <= '0;
        else              symCnt <= symCnt + 1'b1;
      end
    end
  end

  // R4: the count never passes the limit latched for the window
  p_cnt_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (symCnt != '0) |-> (symCnt <= limitReg));

  // R7: idle cycles leave the count alone
  p_idle_cnt_r7: assert property (@(posedge clk) disable iff (rst)
    !symValid |=> $stable(symCnt));

  // R8: the latched limit only changes when a window opens
  p_limit_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(symValid && atStart) |=> $stable(limitReg));
endmodule

// File: rtl/lock_datapath.sv
module lock_datapath
  import qpsk_lock_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  lockStrobes_t               strobes,
  input  logic signed [SAMPLE_W-1:0] iSample,
  input  logic signed [SAMPLE_W-1:0] qSample,
  input  logic        [ACC_W-1:0]    threshold,
  output logic        [ACC_W-1:0]    accSum,
  output logic                       lockFlag
);
  localparam int MAG_W = SAMPLE_W - 1;

  logic signed [SAMPLE_W-1:0] lane [2];
  logic        [MAG_W-1:0]    magLane [2];
  logic        [MAG_W-1:0]    metric;
  logic        [ACC_W-1:0]    acc;
  logic        [ACC_W-1:0]    accBase;
  logic        [ACC_W:0]      accWide;
  logic        [ACC_W-1:0]    accNext;

  assign lane[0] = iSample;
  assign lane[1] = qSample;

  for (genvar g = 0; g < 2; g++) begin : g_mag
    lock_mag #(.SAMPLE_W(SAMPLE_W)) u_mag (
      .sample (lane[g]),
      .mag    (magLane[g])
    );
  end

  // comparator-based difference: larger magnitude minus smaller (R3)
  always_comb begin
    if (magLane[0] >= magLane[1]) metric = magLane[0] - magLane[1];
    else                          metric = magLane[1] - magLane[0];
    accBase = strobes.first ? '0 : acc;
    accWide = {1'b0, accBase} + {{(ACC_W + 1 - MAG_W){1'b0}}, metric};
    accNext = accWide[ACC_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      accSum   <= '0;
      lockFlag <= 1'b0;
    end else if (strobes.take) begin
      acc <= accNext;
      if (strobes.last) begin
        accSum   <= accNext;
        lockFlag <= (accNext > threshold);
      end
    end
  end

  // R9: the running sum never wraps
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (rst)
    strobes.take |-> !accWide[ACC_W]);

  // R7: idle cycles leave the accumulator alone
  p_idle_acc_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes.take |=> $stable(acc));

  // R3: the metric never exceeds the larger magnitude
  p_metric_bound_r3: assert property (@(posedge clk) disable iff (rst)
    strobes.take |-> (metric <= magLane[0] || metric <= magLane[1]));
endmodule

// File: rtl/qpsk_lock_detect.sv
module qpsk_lock_detect
  import qpsk_lock_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int MAX_WIN  = 256,
  parameter int ACC_W    = 16,
  localparam int CNT_W   = $clog2(MAX_WIN)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       symValid,
  input  logic signed [SAMPLE_W-1:0] iSample,
  input  logic signed [SAMPLE_W-1:0] qSample,
  input  logic        [ACC_W-1:0]    threshold,
  input  logic        [CNT_W-1:0]    winLenM1,
  output logic                       lockFlag,
  output logic        [ACC_W-1:0]    accSum,
  output logic                       winDone
);
  lockStrobes_t strobes;

  lock_control #(.CNT_W(CNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .symValid (symValid),
    .winLenM1 (winLenM1),
    .strobes  (strobes),
    .winDone  (winDone)
  );

  lock_datapath #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .iSample   (iSample),
    .qSample   (qSample),
    .threshold (threshold),
    .accSum    (accSum),
    .lockFlag  (lockFlag)
  );

  // R6: the decision moves only with the done pulse
  p_lock_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !winDone |-> $stable(lockFlag));

  // R6: at the done pulse the decision is the strict compare of the shown sum
  p_lock_rule_r6: assert property (@(posedge clk) disable iff (rst)
    winDone |-> (lockFlag == (accSum > $past(threshold))));

  // R5: the shown sum holds between windows
  p_sum_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !winDone |-> $stable(accSum));

  // R4: a window closes only on a strobed cycle
  p_done_after_take_r4: assert property (@(posedge clk) disable iff (rst)
    !symValid |=> !winDone);
endmodule

// File: tb/qpsk_lock_detect_test.sv
module qpsk_lock_detect_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              symValid = 1'b0;
  logic signed [7:0] iSample = '0;
  logic signed [7:0] qSample = '0;
  logic [15:0]       threshold = '0;
  logic [7:0]        winLenM1 = '0;
  logic              lockFlag;
  logic [15:0]       accSum;
  logic              winDone;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  qpsk_lock_detect uut (
    .clk(clk), .rst(rst), .symValid(symValid), .iSample(iSample),
    .qSample(qSample), .threshold(threshold), .winLenM1(winLenM1),
    .lockFlag(lockFlag), .accSum(accSum), .winDone(winDone)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int refMag(input int x);
    if (x == -128) return 127;
    return (x < 0) ? -x : x;
  endfunction

  function automatic int refMetric(input int a, input int b);
    int ma = refMag(a);
    int mb = refMag(b);
    return (ma > mb) ? ma - mb : mb - ma;
  endfunction

  // drive at negedge, let one edge pass, return at the next negedge
  task automatic step(input logic v, input logic signed [7:0] i, input logic signed [7:0] q);
    symValid = v; iSample = i; qSample = q;
    @(posedge clk);
    @(negedge clk);
  endtask

  logic signed [7:0] iv [128];
  logic signed [7:0] qv [128];
  logic [15:0]       lfsr = 16'hACE1;

  function automatic logic [15:0] nextLfsr(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // one 128-symbol window with idle gaps carrying garbage
  task automatic longWindow(input int expSum, input logic [15:0] thr, input bit expLock,
                            input bit changeLen, input string tag);
    bit prevLock;
    logic [15:0] prevSum;
    threshold = thr;
    winLenM1  = 8'd127;
    prevLock  = lockFlag;
    prevSum   = accSum;
    for (int k = 0; k < 128; k++) begin
      step(1'b1, iv[k], qv[k]);
      if (changeLen && k == 0) winLenM1 = 8'd2;   // R8: must not shorten this window
      if (k != 127) begin
        chk(winDone == 1'b0, {tag, " R4 early done"}, winDone, 0);
        chk(lockFlag == prevLock, {tag, " R6 lock hold"}, lockFlag, prevLock);
        if (k % 5 == 0) begin
          for (int g = 0; g < 2; g++) begin
            lfsr = nextLfsr(lfsr);
            step(1'b0, 8'sh80, lfsr[7:0]);
            chk(winDone == 1'b0 && accSum == prevSum, {tag, " R7 idle"}, accSum, prevSum);
          end
        end
      end
    end
    chk(winDone == 1'b1, {tag, " R4 done"}, winDone, 1);
    chk(accSum == expSum[15:0], {tag, " R5 sum"}, accSum, expSum);
    chk(lockFlag == expLock, {tag, " R6 strict compare"}, lockFlag, expLock);
    winLenM1 = 8'd127;
  endtask

  initial begin
    int sum;
    int m;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk(lockFlag == 1'b0, "R1 lock after reset", lockFlag, 0);
    chk(winDone == 1'b0, "R1 done after reset", winDone, 0);
    chk(accSum == 16'd0, "R1 sum after reset", accSum, 0);
    rst = 1'b0;
    step(1'b0, 8'sd0, 8'sd0);
    chk(lockFlag == 1'b0 && winDone == 1'b0, "R1 idle after reset", lockFlag, 0);

    // exhaustive one-symbol windows: R2, R3, R6
    winLenM1  = 8'd0;
    threshold = 16'd63;
    for (int a = -128; a < 128; a++) begin
      for (int b = -128; b < 128; b++) begin
        step(1'b1, a[7:0], b[7:0]);
        m = refMetric(a, b);
        chk(winDone == 1'b1, "R4 single-symbol done", winDone, 1);
        chk(accSum == m[15:0], "R2 R3 metric", accSum, m);
        chk(lockFlag == (m > 63), "R6 single compare", lockFlag, m > 63);
      end
    end
    step(1'b0, 8'sd5, 8'sd1);
    chk(winDone == 1'b0, "R4 done one cycle", winDone, 0);

    // 128-symbol windows
    sum = 0;
    for (int k = 0; k < 128; k++) begin
      lfsr = nextLfsr(lfsr); iv[k] = lfsr[7:0];
      lfsr = nextLfsr(lfsr); qv[k] = lfsr[7:0];
      sum += refMetric(iv[k], qv[k]);
    end
    longWindow(sum, 16'(sum - 1), 1'b1, 1'b0, "W128a");
    longWindow(sum, 16'(sum), 1'b0, 1'b1, "W128b");

    // R8 short: length 4, changed to 1 after first symbol
    winLenM1 = 8'd3;
    threshold = 16'd0;
    step(1'b1, 8'sd10, 8'sd0);
    winLenM1 = 8'd0;
    step(1'b1, 8'sd20, 8'sd0);
    chk(winDone == 1'b0, "R8 length kept", winDone, 0);
    step(1'b1, 8'sd30, 8'sd0);
    step(1'b1, 8'sd40, 8'sd0);
    chk(winDone == 1'b1 && accSum == 16'd100, "R8 window of four", accSum, 100);
    step(1'b1, 8'sd7, 8'sd2);
    chk(winDone == 1'b1 && accSum == 16'd5, "R8 new length used", accSum, 5);

    // R9: 256 full-scale metrics
    winLenM1  = 8'd255;
    threshold = 16'd32511;
    for (int k = 0; k < 256; k++) step(1'b1, 8'sh80, 8'sd0);
    chk(winDone == 1'b1, "R9 done", winDone, 1);
    chk(accSum == 16'd32512, "R9 no overflow", accSum, 32512);
    chk(lockFlag == 1'b1, "R9 lock", lockFlag, 1);
    step(1'b0, 8'sd0, 8'sd0);
    chk(accSum == 16'd32512 && winDone == 1'b0, "R5 sum held", accSum, 32512);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule